// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the control unit for a processor datapath that executes each instruction over several clock cycles and uses a single memory for both instructions and data. It holds a four-bit state number. In every state it drives the datapath's write enables and multiplexer selects. The control vector is a pure function of the current state, apart from the PC load strobe, which also looks at the ALU zero flag while a branch is resolving.

Every instruction starts with a fetch state and then a decode state. Decode is the only point where the opcode is consulted. From there each instruction class walks its own fixed chain of numbered states and then drops back to fetch. Each state has one of three next-state actions: step to the following state number, dispatch on the opcode, or return to fetch. The supported classes are register-register ALU operations, OR with a zero-extended immediate, word load, word store, and branch on equality. The five opcode values are parameters.

Top module: `mcc_ctrl`

## Requirements
- R1: While rst_n is low, state reads 0 and every enable and select output is 0, whatever opcode and alu_zero carry. Releasing reset leaves the block in fetch (state 0).
- R2: State 0 (fetch) drives pc_wr=1 and ir_wr=1, addr_sel_data=0, alu_a_reg=0 (PC), alu_b_sel=01 (constant four), alu_op=00 (add), ext_sign=0 and pc_src_tgt=0. All other enables are 0. The next state is always 1.
- R3: State 1 (decode) drives alu_a_reg=0, alu_b_sel=11 (extended immediate shifted left by two), alu_op=00 and ext_sign=1 (sign extension), with no enable set. Its successor depends on opcode. With the default values, 6'h00 (register op) goes to 4, 6'h0D (OR immediate) goes to 6, 6'h23 (load) goes to 8, 6'h2B (store) goes to 11, 6'h04 (branch) goes to 3, and any other value goes to 0.
- R4: Register op. State 4 drives alu_a_reg=1, alu_b_sel=00 (register B) and alu_op=10 (function field), then steps to 5. State 5 drives rf_wr=1 and rf_dst_rd=1, then returns to 0.
- R5: OR immediate. State 6 drives alu_a_reg=1, alu_b_sel=10 (extended immediate), alu_op=11 (OR) and ext_sign=0, then steps to 7. State 7 drives rf_wr=1 with rf_dst_rd=0 and rf_from_mem=0, then returns to 0.
- R6: Load. State 8 drives alu_a_reg=1, alu_b_sel=10, alu_op=00 and ext_sign=1. State 9 drives only addr_sel_data=1. State 10 drives rf_wr=1 and rf_from_mem=1 with rf_dst_rd=0. The chain is 8, 9, 10, 0.
- R7: Store. State 11 drives the same address computation as state 8. State 12 drives addr_sel_data=1 and mem_wr=1. The chain is 11, 12, 0.
- R8: Branch. State 3 drives alu_a_reg=1, alu_b_sel=00, alu_op=01 (subtract), pc_wr_cond=1 and pc_src_tgt=1, then returns to 0.
- R9: pc_en is high exactly when pc_wr is high, or when pc_wr_cond is high and alu_zero is high. Outside state 3, alu_zero has no effect on any output.
- R10: mem_wr is high only in state 12, rf_wr only in states 5, 7 and 10, and ir_wr only in state 0. At most one of the three is high in any cycle.
- R11: opcode is ignored in every state other than 1. Changing it part-way through an instruction does not alter that instruction's remaining states or outputs.
- R12: An asynchronous reset asserted in the middle of an instruction forces state 0 and all-zero outputs at once. After release, execution restarts at fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opcode | input | OPC_W | Opcode field of the instruction register |
| alu_zero | input | 1 | ALU result-is-zero flag |
| state | output | 4 | Current state number |
| pc_wr | output | 1 | Unconditional PC write |
| pc_wr_cond | output | 1 | PC write qualified by alu_zero |
| pc_en | output | 1 | Combined PC load strobe |
| addr_sel_data | output | 1 | Memory address from ALUout (1) or PC (0) |
| mem_wr | output | 1 | Memory write |
| ir_wr | output | 1 | Instruction register write |
| rf_wr | output | 1 | Register file write |
| rf_dst_rd | output | 1 | Destination is rd (1) or rt (0) |
| rf_from_mem | output | 1 | Write data from memory data register (1) or ALUout (0) |
| alu_a_reg | output | 1 | ALU A from register A (1) or PC (0) |
| alu_b_sel | output | 2 | ALU B: 00 reg B, 01 four, 10 imm, 11 imm<<2 |
| alu_op | output | 2 | 00 add, 01 subtract, 10 function field, 11 OR |
| ext_sign | output | 1 | Immediate sign (1) or zero (0) extension |
| pc_src_tgt | output | 1 | PC source ALUout register (1) or ALU result (0) |

## Verification
The assertions assume that opcode is a known value during the decode state, because the dispatch decision is taken there. They also assume that alu_zero is known whenever the branch state is active, since pc_en depends on it only in that state. The stimulus sets both inputs to definite values before each instruction's fetch cycle. It changes them only shortly after a clock edge, so they are steady whenever decode or branch samples them. Reset is driven low from time zero, so every clocked property starts from a defined state.

// File: rtl/mcc_pkg.sv
package mcc_pkg;

    localparam int STATE_W = 4;

    typedef enum logic [STATE_W-1:0] {
        ST_FETCH   = 4'd0,
        ST_DECODE  = 4'd1,
        ST_BRANCH  = 4'd3,
        ST_REG_EXE = 4'd4,
        ST_REG_WB  = 4'd5,
        ST_ORI_EXE = 4'd6,
        ST_ORI_WB  = 4'd7,
        ST_LD_ADDR = 4'd8,
        ST_LD_MEM  = 4'd9,
        ST_LD_WB   = 4'd10,
        ST_ST_ADDR = 4'd11,
        ST_ST_MEM  = 4'd12
    } mcc_state_e;

    typedef enum logic [1:0] {
        ACT_FETCH    = 2'd0,
        ACT_DISPATCH = 2'd1,
        ACT_STEP     = 2'd2
    } mcc_action_e;

    typedef enum logic [1:0] {
        BSRC_REG   = 2'b00,
        BSRC_FOUR  = 2'b01,
        BSRC_IMM   = 2'b10,
        BSRC_IMMSH = 2'b11
    } mcc_bsrc_e;

    typedef enum logic [1:0] {
        AOP_ADD  = 2'b00,
        AOP_SUB  = 2'b01,
        AOP_FUNC = 2'b10,
        AOP_OR   = 2'b11
    } mcc_aop_e;

    typedef struct packed {
        logic      pc_wr;
        logic      pc_wr_cond;
        logic      addr_sel_data;
        logic      mem_wr;
        logic      ir_wr;
        logic      rf_wr;
        logic      rf_dst_rd;
        logic      rf_from_mem;
        logic      alu_a_reg;
        mcc_bsrc_e alu_b_sel;
        mcc_aop_e  alu_op;
        logic      ext_sign;
        logic      pc_src_tgt;
    } mcc_ctrl_t;

    localparam mcc_ctrl_t CTRL_IDLE = '{
        pc_wr: 1'b0, pc_wr_cond: 1'b0, addr_sel_data: 1'b0, mem_wr: 1'b0,
        ir_wr: 1'b0, rf_wr: 1'b0, rf_dst_rd: 1'b0, rf_from_mem: 1'b0,
        alu_a_reg: 1'b0, alu_b_sel: BSRC_REG, alu_op: AOP_ADD,
        ext_sign: 1'b0, pc_src_tgt: 1'b0
    };

endpackage

// File: rtl/mcc_next_state.sv
module mcc_next_state
    import mcc_pkg::*;
#(
    parameter int               OPC_W    = 6,
    parameter logic [OPC_W-1:0] OPC_REG  = 6'h00,
    parameter logic [OPC_W-1:0] OPC_ORI  = 6'h0D,
    parameter logic [OPC_W-1:0] OPC_LD   = 6'h23,
    parameter logic [OPC_W-1:0] OPC_ST   = 6'h2B,
    parameter logic [OPC_W-1:0] OPC_BR   = 6'h04
) (
    input  mcc_state_e       cur,
    input  logic [OPC_W-1:0] opcode,
    output mcc_state_e       nxt
);

    mcc_action_e act;
    mcc_state_e  disp;

    // Per-state sequencing action
    always_comb begin
        unique case (cur)
            ST_FETCH, ST_REG_EXE, ST_ORI_EXE,
            ST_LD_ADDR, ST_LD_MEM, ST_ST_ADDR: act = ACT_STEP;
            ST_DECODE:                        act = ACT_DISPATCH;
            default:                          act = ACT_FETCH;
        endcase
    end

    // Opcode dispatch target, consulted only from decode
    always_comb begin
        if (opcode == OPC_REG)      disp = ST_REG_EXE;
        else if (opcode == OPC_ORI) disp = ST_ORI_EXE;
        else if (opcode == OPC_LD)  disp = ST_LD_ADDR;
        else if (opcode == OPC_ST)  disp = ST_ST_ADDR;
        else if (opcode == OPC_BR)  disp = ST_BRANCH;
        else                        disp = ST_FETCH;
    end

    always_comb begin
        unique case (act)
            ACT_STEP:     nxt = mcc_state_e'(cur + 4'd1);
            ACT_DISPATCH: nxt = disp;
            default:      nxt = ST_FETCH;
        endcase
    end

endmodule

// File: rtl/mcc_ctrl_decode.sv
module mcc_ctrl_decode
    import mcc_pkg::*;
(
    input  mcc_state_e cur,
    output mcc_ctrl_t  ctl
);

    always_comb begin
        ctl = CTRL_IDLE;
        unique case (cur)
            ST_FETCH: begin
                ctl.pc_wr     = 1'b1;
                ctl.ir_wr     = 1'b1;
                ctl.alu_b_sel = BSRC_FOUR;
                ctl.alu_op    = AOP_ADD;
            end
            ST_DECODE: begin
                ctl.alu_b_sel = BSRC_IMMSH;
                ctl.alu_op    = AOP_ADD;
                ctl.ext_sign  = 1'b1;
            end
            ST_BRANCH: begin
                ctl.alu_a_reg  = 1'b1;
                ctl.alu_b_sel  = BSRC_REG;
                ctl.alu_op     = AOP_SUB;
                ctl.pc_wr_cond = 1'b1;
                ctl.pc_src_tgt = 1'b1;
            end
            ST_REG_EXE: begin
                ctl.alu_a_reg = 1'b1;
                ctl.alu_b_sel = BSRC_REG;
                ctl.alu_op    = AOP_FUNC;
            end
            ST_REG_WB: begin
                ctl.rf_wr     = 1'b1;
                ctl.rf_dst_rd = 1'b1;
            end
            ST_ORI_EXE: begin
                ctl.alu_a_reg = 1'b1;
                ctl.alu_b_sel = BSRC_IMM;
                ctl.alu_op    = AOP_OR;
                ctl.ext_sign  = 1'b0;
            end
            ST_ORI_WB: begin
                ctl.rf_wr = 1'b1;
            end
            ST_LD_ADDR, ST_ST_ADDR: begin
                ctl.alu_a_reg = 1'b1;
                ctl.alu_b_sel = BSRC_IMM;
                ctl.alu_op    = AOP_ADD;
                ctl.ext_sign  = 1'b1;
            end
            ST_LD_MEM: begin
                ctl.addr_sel_data = 1'b1;
            end
            ST_LD_WB: begin
                ctl.rf_wr       = 1'b1;
                ctl.rf_from_mem = 1'b1;
            end
            ST_ST_MEM: begin
                ctl.addr_sel_data = 1'b1;
                ctl.mem_wr        = 1'b1;
            end
            default: ctl = CTRL_IDLE;
        endcase
    end

endmodule

// File: rtl/mcc_ctrl.sv
module mcc_ctrl
    import mcc_pkg::*;
#(
    parameter int               OPC_W   = 6,
    parameter logic [OPC_W-1:0] OPC_REG = 6'h00,
    parameter logic [OPC_W-1:0] OPC_ORI = 6'h0D,
    parameter logic [OPC_W-1:0] OPC_LD  = 6'h23,
    parameter logic [OPC_W-1:0] OPC_ST  = 6'h2B,
    parameter logic [OPC_W-1:0] OPC_BR  = 6'h04
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OPC_W-1:0] opcode,
    input  logic             alu_zero,
    output logic [3:0]       state,
    output logic             pc_wr,
    output logic             pc_wr_cond,
    output logic             pc_en,
    output logic             addr_sel_data,
    output logic             mem_wr,
    output logic             ir_wr,
    output logic             rf_wr,
    output logic             rf_dst_rd,
    output logic             rf_from_mem,
    output logic             alu_a_reg,
    output logic [1:0]       alu_b_sel,
    output logic [1:0]       alu_op,
    output logic             ext_sign,
    output logic             pc_src_tgt
);

    typedef struct packed {
        mcc_state_e st;
    } regs_t;

    localparam regs_t REGS_RST = '{st: ST_FETCH};

    regs_t      regs_d, regs_q;
    mcc_state_e nxt_st;
    mcc_ctrl_t  ctl_raw, ctl;

    mcc_next_state #(
        .OPC_W  (OPC_W),
        .OPC_REG(OPC_REG),
        .OPC_ORI(OPC_ORI),
        .OPC_LD (OPC_LD),
        .OPC_ST (OPC_ST),
        .OPC_BR (OPC_BR)
    ) i_next (
        .cur   (regs_q.st),
        .opcode(opcode),
        .nxt   (nxt_st)
    );

    mcc_ctrl_decode i_dec (
        .cur(regs_q.st),
        .ctl(ctl_raw)
    );

    always_comb begin
        regs_d    = regs_q;
        regs_d.st = nxt_st;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= REGS_RST;
        else        regs_q <= regs_d;
    end

    // Hold every enable low while reset is applied
    always_comb begin
        ctl = rst_n ? ctl_raw : CTRL_IDLE;
    end

    assign state         = regs_q.st;
    assign pc_wr         = ctl.pc_wr;
    assign pc_wr_cond    = ctl.pc_wr_cond;
    assign pc_en         = ctl.pc_wr | (ctl.pc_wr_cond & alu_zero);
    assign addr_sel_data = ctl.addr_sel_data;
    assign mem_wr        = ctl.mem_wr;
    assign ir_wr         = ctl.ir_wr;
    assign rf_wr         = ctl.rf_wr;
    assign rf_dst_rd     = ctl.rf_dst_rd;
    assign rf_from_mem   = ctl.rf_from_mem;
    assign alu_a_reg     = ctl.alu_a_reg;
    assign alu_b_sel     = ctl.alu_b_sel;
    assign alu_op        = ctl.alu_op;
    assign ext_sign      = ctl.ext_sign;
    assign pc_src_tgt    = ctl.pc_src_tgt;

    // Fetch always hands over to decode
    assert_fetch_to_decode_R2: assert property (@(posedge clk) disable iff (!rst_n)
        state == 4'd0 |=> state == 4'd1);

    // Decode lands only on a class entry state or back on fetch
    assert_dispatch_target_R3: assert property (@(posedge clk) disable iff (!rst_n)
        state == 4'd1 |=> (state == 4'd0 || state == 4'd3 || state == 4'd4 ||
                           state == 4'd6 || state == 4'd8 || state == 4'd11));

    // Register-op execute steps into its write-back
    assert_reg_chain_R4: assert property (@(posedge clk) disable iff (!rst_n)
        state == 4'd4 |=> (state == 4'd5 && rf_wr && rf_dst_rd));

    // Any register write ends the instruction
    assert_wb_returns_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rf_wr |=> state == 4'd0);

    // Load address leads to a data-side memory access
    assert_load_chain_R6: assert property (@(posedge clk) disable iff (!rst_n)
        state == 4'd8 |=> (addr_sel_data && !mem_wr));

    // A store write ends the instruction
    assert_store_returns_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |=> state == 4'd0);

    // An untaken branch never loads the PC
    assert_branch_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_wr_cond && !alu_zero) |-> !pc_en);

    // PC loads happen only in fetch or a taken branch
    assert_pc_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pc_en |-> (state == 4'd0 || (state == 4'd3 && alu_zero)));

    // Storage-side writes are mutually exclusive
    assert_write_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_wr, rf_wr, ir_wr}));

    assert_ir_in_fetch_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ir_wr |-> state == 4'd0);

endmodule

// File: tb/test_mcc_ctrl.sv
module test_mcc_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] opcode = 6'h00;
    logic       alu_zero = 1'b0;
    logic [3:0] state;
    logic       pc_wr, pc_wr_cond, pc_en, addr_sel_data, mem_wr, ir_wr;
    logic       rf_wr, rf_dst_rd, rf_from_mem, alu_a_reg, ext_sign, pc_src_tgt;
    logic [1:0] alu_b_sel, alu_op;

    int n_run  = 0;
    int n_fail = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    mcc_ctrl i_mcc_ctrl (
        .clk(clk), .rst_n(rst_n), .opcode(opcode), .alu_zero(alu_zero),
        .state(state), .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond), .pc_en(pc_en),
        .addr_sel_data(addr_sel_data), .mem_wr(mem_wr), .ir_wr(ir_wr),
        .rf_wr(rf_wr), .rf_dst_rd(rf_dst_rd), .rf_from_mem(rf_from_mem),
        .alu_a_reg(alu_a_reg), .alu_b_sel(alu_b_sel), .alu_op(alu_op),
        .ext_sign(ext_sign), .pc_src_tgt(pc_src_tgt)
    );

    // Vector order: pc_wr pc_wr_cond addr_sel mem_wr ir_wr rf_wr rf_dst_rd
    //               rf_from_mem alu_a_reg alu_b_sel[2] alu_op[2] ext_sign pc_src_tgt
    function automatic logic [14:0] exp_vec(input logic [3:0] s);
        case (s)
            4'd0:  return 15'b1_0_0_0_1_0_0_0_0_01_00_0_0;
            4'd1:  return 15'b0_0_0_0_0_0_0_0_0_11_00_1_0;
            4'd3:  return 15'b0_1_0_0_0_0_0_0_1_00_01_0_1;
            4'd4:  return 15'b0_0_0_0_0_0_0_0_1_00_10_0_0;
            4'd5:  return 15'b0_0_0_0_0_1_1_0_0_00_00_0_0;
            4'd6:  return 15'b0_0_0_0_0_0_0_0_1_10_11_0_0;
            4'd7:  return 15'b0_0_0_0_0_1_0_0_0_00_00_0_0;
            4'd8:  return 15'b0_0_0_0_0_0_0_0_1_10_00_1_0;
            4'd9:  return 15'b0_0_1_0_0_0_0_0_0_00_00_0_0;
            4'd10: return 15'b0_0_0_0_0_1_0_1_0_00_00_0_0;
            4'd11: return 15'b0_0_0_0_0_0_0_0_1_10_00_1_0;
            4'd12: return 15'b0_0_1_1_0_0_0_0_0_00_00_0_0;
            default: return 15'b0;
        endcase
    endfunction

    function automatic logic [14:0] act_vec();
        return {pc_wr, pc_wr_cond, addr_sel_data, mem_wr, ir_wr, rf_wr, rf_dst_rd,
                rf_from_mem, alu_a_reg, alu_b_sel, alu_op, ext_sign, pc_src_tgt};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h (t=%0t)", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    // Entry: opcode[33:28] zero[27] length[26:24] path[23:0], state k at nibble k
    localparam int N_VEC = 9;
    localparam logic [33:0] VECS [N_VEC] = '{
        {6'h00, 1'b0, 3'd4, 24'h005410},  // R4 register op
        {6'h00, 1'b1, 3'd4, 24'h005410},  // R9 zero ignored
        {6'h0D, 1'b0, 3'd4, 24'h007610},  // R5 OR immediate
        {6'h23, 1'b1, 3'd5, 24'h0A9810},  // R6 load
        {6'h2B, 1'b0, 3'd4, 24'h00CB10},  // R7 store
        {6'h04, 1'b1, 3'd3, 24'h000310},  // R8 taken branch
        {6'h04, 1'b0, 3'd3, 24'h000310},  // R8 untaken branch
        {6'h3F, 1'b0, 3'd2, 24'h000010},  // R3 unknown opcode
        {6'h02, 1'b1, 3'd2, 24'h000010}   // R3 unknown opcode
    };

    initial begin
        // R1: outputs idle during reset, even with live inputs
        opcode   = 6'h23;
        alu_zero = 1'b1;
        repeat (3) @(posedge clk);
        #2;
        chk("R1 state in reset", state, 4'd0);
        chk("R1 vector in reset", act_vec(), 15'b0);
        chk("R1 pc_en in reset", pc_en, 1'b0);
        rst_n = 1'b1;
        #2;
        chk("R1 fetch after release", act_vec(), exp_vec(4'd0));

        // Table walk: R2..R10 per state
        for (int v = 0; v < N_VEC; v++) begin
            logic [3:0] s;
            opcode   = VECS[v][33:28];
            alu_zero = VECS[v][27];
            for (int k = 0; k < int'(VECS[v][26:24]); k++) begin
                s = VECS[v][4*k +: 4];
                chk($sformatf("R3 state v%0d k%0d", v, k), state, s);
                chk($sformatf("R2 vector v%0d s%0d", v, s), act_vec(), exp_vec(s));
                chk($sformatf("R9 pc_en v%0d s%0d", v, s), pc_en,
                    (s == 4'd0) || (s == 4'd3 && alu_zero));
                chk($sformatf("R10 excl v%0d", v), $countones({mem_wr, rf_wr, ir_wr}) <= 1, 1'b1);
                step();
            end
            chk($sformatf("R3 return v%0d", v), state, 4'd0);
        end

        // R11: opcode changes after decode do not redirect a register op
        opcode = 6'h00;
        step();                       // decode
        step();                       // state 4
        chk("R11 entered reg exe", state, 4'd4);
        opcode = 6'h23;
        step();
        chk("R11 stays on reg path", state, 4'd5);
        chk("R11 reg wb vector", act_vec(), exp_vec(4'd5));
        opcode = 6'h2B;
        step();
        chk("R11 back to fetch", state, 4'd0);

        // R12: reset in the middle of a load
        opcode = 6'h23;
        step(); step(); step();
        chk("R12 in load mem", state, 4'd9);
        rst_n = 1'b0;
        #1;
        chk("R12 async state", state, 4'd0);
        chk("R12 async vector", act_vec(), 15'b0);
        step();
        rst_n = 1'b1;
        #2;
        chk("R12 restart fetch", act_vec(), exp_vec(4'd0));
        step();
        chk("R12 then decode", state, 4'd1);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000 && !done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule